// File: doc/BRIEF.md
# Single-Cycle 32-bit Processor Core (Integer Subset)

This block is a 32-bit processor core that retires one instruction on every rising clock edge. It supports a small integer subset: register-register addition, addition with an immediate, word load, word store, branch-if-equal and an absolute jump. It has no pipeline. In each cycle, combinational logic fetches the word at the program counter, decodes it, reads two source registers, forms a sum and, for loads and stores, accesses the data memory. On the next edge, the program counter, the register file and the data memory all take their new values together.

The instruction memory and the data memory are ideal and separate. Each reads combinationally, writes on the clock edge and has no ready handshake. A backdoor load port lets the surrounding environment (normally a testbench) fill either memory word by word, usually while the core is held in reset. A debug port returns the contents of any selected register and the current program counter. Both are combinational and need no extra cycles.

Top module: `scp_core`

## Requirements
- R1: When `rst_n` is low at a rising edge, that edge sets the program counter to 0 and all 32 registers to 0. Memory contents are kept.
- R2: Register 0 always reads as 0. Any write aimed at it is discarded.
- R3: An instruction with opcode 0x00 in bits [31:26] and funct 0x20 in bits [5:0] writes reg[bits 25:21] + reg[bits 20:16] into reg[bits 15:11] and advances the PC by 4.
- R4: Opcode 0x08 writes reg[bits 25:21] + sign-extended bits [15:0] into reg[bits 20:16] and advances the PC by 4.
- R5: Opcode 0x23 loads into reg[bits 20:16] the data word at byte address reg[bits 25:21] + sign-extended bits [15:0]. The word index is address bits [DAW+1:2], so the two low address bits are ignored.
- R6: Opcode 0x2B stores reg[bits 20:16] at the effective address formed as in R5, writes no register and advances the PC by 4.
- R7: Opcode 0x04 writes nothing. If reg[bits 25:21] equals reg[bits 20:16], the next PC is PC + 4 + (sign-extended bits [15:0] × 4); otherwise it is PC + 4.
- R8: Opcode 0x02 sets the next PC to {PC[31:28], bits [25:0], 2'b00} and writes nothing.
- R9: Any other opcode, and any opcode-0x00 word whose funct is not 0x20, writes nothing and only advances the PC by 4.
- R10: `dbg_reg` shows the register selected by `dbg_sel` combinationally, and `dbg_pc` shows the current PC.
- R11: A backdoor load writes `ld_word` at word index `ld_idx` of the instruction memory (`ld_imem_we`) or the data memory (`ld_dmem_we`) on the rising edge. A backdoor data write takes precedence over a store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_imem_we | input | 1 | Backdoor write strobe for instruction memory |
| ld_dmem_we | input | 1 | Backdoor write strobe for data memory |
| ld_idx | input | LDW | Backdoor word index |
| ld_word | input | 32 | Backdoor write data |
| dbg_sel | input | 5 | Register number to observe |
| dbg_reg | output | 32 | Contents of the selected register |
| dbg_pc | output | 32 | Current program counter |

## Verification
The hardest situations to reach are the cases that leave no trace on any register: a discarded write to register 0, an unsupported funct, a skipped instruction after a taken branch or a jump, and the low address bits that a load ignores. To reach them, one preloaded program sends each of these cases through a later instruction whose result lands in a register the debug port can read. The same run records the PC after every edge, so each taken branch, not-taken branch, jump and self-loop shows up as a PC value at a known cycle. A reset applied in the middle of the run then checks that the PC and the registers are cleared while the program in memory survives.

// File: rtl/scp_pkg.sv
`timescale 1ns/1ps
// Package scp_pkg
// Shared constants and the decoded control word of the single-cycle core.
// Assumes the 32-bit fixed-width encoding with opcode in bits [31:26].
package scp_pkg;
    localparam int XLEN   = 32;
    localparam int NREG   = 32;
    localparam int RSEL_W = $clog2(NREG);

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] FN_ADD   = 6'h20;

    typedef struct packed {
        logic reg_we;   // write a general register
        logic dst_rd;   // destination from bits [15:11] instead of [20:16]
        logic src_imm;  // second adder operand is the sign-extended immediate
        logic ld_sel;   // write-back value comes from data memory
        logic st_en;    // store to data memory
        logic br_eq;    // conditional branch on equality
        logic jmp;      // absolute jump
    } ctrl_t;
endpackage

// File: rtl/scp_decode.sv
`timescale 1ns/1ps
// Module scp_decode
// Purely combinational decode of one instruction word into the control word.
// Assumes unknown opcodes and unsupported functs must act as no-ops.
module scp_decode
    import scp_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output ctrl_t           ctrl
);
    logic [5:0] opc;
    logic [5:0] fn;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    // Map the opcode (and funct) to control bits, defaulting to a no-op.
    always_comb begin
        ctrl = '0;
        case (opc)
            OP_RTYPE: begin
                if (fn == FN_ADD) begin
                    ctrl.reg_we = 1'b1;
                    ctrl.dst_rd = 1'b1;
                end
            end
            OP_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
            end
            OP_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.src_imm = 1'b1;
                ctrl.ld_sel  = 1'b1;
            end
            OP_SW: begin
                ctrl.src_imm = 1'b1;
                ctrl.st_en   = 1'b1;
            end
            OP_BEQ:  ctrl.br_eq = 1'b1;
            OP_J:    ctrl.jmp   = 1'b1;
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/scp_regfile.sv
`timescale 1ns/1ps
// Module scp_regfile
// General register file: two operand read ports plus one debug read port,
// all combinational; one write port updated on the rising edge.
// Assumes entry 0 is hard zero; synchronous active-low reset clears all.
module scp_regfile #(
    parameter int NUM = 32,
    parameter int W   = 32,
    localparam int AW = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] sel_a,
    output logic [W-1:0]  val_a,
    input  logic [AW-1:0] sel_b,
    output logic [W-1:0]  val_b,
    input  logic [AW-1:0] sel_d,
    output logic [W-1:0]  val_d,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_sel,
    input  logic [W-1:0]  wr_val
);
    logic [W-1:0] regs [NUM];

    // Clear on reset, otherwise store one value unless it targets entry 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM; i++) regs[i] <= '0;
        end else if (wr_en && (wr_sel != '0)) begin
            regs[wr_sel] <= wr_val;
        end
    end

    // Combinational reads from current contents.
    assign val_a = regs[sel_a];
    assign val_b = regs[sel_b];
    assign val_d = regs[sel_d];
endmodule

// File: rtl/scp_mem.sv
`timescale 1ns/1ps
// Module scp_mem
// Ideal word memory: combinational read, write on the rising edge.
// Assumes no handshake and no reset of contents; indices wrap to depth.
module scp_mem #(
    parameter int WORDS = 64,
    parameter int W     = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic [AW-1:0] rd_idx,
    output logic [W-1:0]  rd_val,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_val
);
    logic [W-1:0] cells [WORDS];

    // Edge-triggered write of one word.
    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_idx] <= wr_val;
    end

    // Combinational read.
    assign rd_val = cells[rd_idx];
endmodule

// File: rtl/scp_core.sv
`timescale 1ns/1ps
// Module scp_core
// Single-cycle 32-bit core: add, add-immediate, load word, store word,
// branch-if-equal and jump. PC, registers and data memory all update on
// the same edge. Memories are ideal; a backdoor port fills them.
// Assumes synchronous active-low reset; backdoor data writes win over stores.
module scp_core
    import scp_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS),
    localparam int LDW = (IAW > DAW) ? IAW : DAW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_imem_we,
    input  logic              ld_dmem_we,
    input  logic [LDW-1:0]    ld_idx,
    input  logic [XLEN-1:0]   ld_word,
    input  logic [RSEL_W-1:0] dbg_sel,
    output logic [XLEN-1:0]   dbg_reg,
    output logic [XLEN-1:0]   dbg_pc
);
    logic [XLEN-1:0]   pc;
    logic [XLEN-1:0]   instr;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   rs_val, rt_val;
    logic [XLEN-1:0]   imm_ext, alu_b, alu_y;
    logic [XLEN-1:0]   dm_rdata;
    logic [XLEN-1:0]   pc_plus4, br_tgt, j_tgt;
    logic              rf_we;
    logic [RSEL_W-1:0] rf_waddr;
    logic [XLEN-1:0]   rf_wdata;
    logic              dm_we;
    logic [DAW-1:0]    dm_widx;
    logic              take_br;

    scp_mem #(.WORDS(IMEM_WORDS), .W(XLEN)) u_imem (
        .clk    (clk),
        .rd_idx (pc[IAW+1:2]),
        .rd_val (instr),
        .wr_en  (ld_imem_we),
        .wr_idx (ld_idx[IAW-1:0]),
        .wr_val (ld_word)
    );

    scp_decode u_dec (
        .instr (instr),
        .ctrl  (ctrl)
    );

    scp_regfile #(.NUM(NREG), .W(XLEN)) u_rf (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel_a  (instr[25:21]),
        .val_a  (rs_val),
        .sel_b  (instr[20:16]),
        .val_b  (rt_val),
        .sel_d  (dbg_sel),
        .val_d  (dbg_reg),
        .wr_en  (rf_we),
        .wr_sel (rf_waddr),
        .wr_val (rf_wdata)
    );

    // Operand selection and the single adder shared by all data instructions.
    always_comb begin
        imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};
        alu_b   = ctrl.src_imm ? imm_ext : rt_val;
        alu_y   = rs_val + alu_b;
    end

    // Data memory write steering: backdoor first, then core store.
    always_comb begin
        dm_we   = ld_dmem_we | (ctrl.st_en & rst_n);
        dm_widx = ld_dmem_we ? ld_idx[DAW-1:0] : alu_y[DAW+1:2];
    end

    scp_mem #(.WORDS(DMEM_WORDS), .W(XLEN)) u_dmem (
        .clk    (clk),
        .rd_idx (alu_y[DAW+1:2]),
        .rd_val (dm_rdata),
        .wr_en  (dm_we),
        .wr_idx (dm_widx),
        .wr_val (ld_dmem_we ? ld_word : rt_val)
    );

    // Register write-back selection.
    always_comb begin
        rf_we    = ctrl.reg_we;
        rf_waddr = ctrl.dst_rd ? instr[15:11] : instr[20:16];
        rf_wdata = ctrl.ld_sel ? dm_rdata : alu_y;
    end

    // Candidate next-PC values.
    always_comb begin
        pc_plus4 = pc + 32'd4;
        br_tgt   = pc_plus4 + {imm_ext[XLEN-3:0], 2'b00};
        j_tgt    = {pc[31:28], instr[25:0], 2'b00};
        take_br  = ctrl.br_eq && (rs_val == rt_val);
    end

    // Program counter update.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= '0;
        else if (ctrl.jmp) pc <= j_tgt;
        else if (take_br)  pc <= br_tgt;
        else               pc <= pc_plus4;
    end

    assign dbg_pc = pc;
endmodule

// File: rtl/scp_core_chk.sv
`timescale 1ns/1ps
// Module scp_core_chk
// Assertion checker bound into scp_core; observes PC, fetched word,
// operand values and write strobes.
module scp_core_chk
    import scp_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   pc,
    input logic [XLEN-1:0]   instr,
    input logic [XLEN-1:0]   rs_val,
    input logic [XLEN-1:0]   rt_val,
    input logic              rf_we,
    input logic              dm_we,
    input logic              ld_dmem_we
);
    logic [5:0]      opc;
    logic [XLEN-1:0] off4;

    assign opc  = instr[31:26];
    assign off4 = {{(XLEN-18){instr[15]}}, instr[15:0], 2'b00};

    // R1: reset forces the PC to zero
    a_r1_pc_cleared: assert property (@(posedge clk)
        !rst_n |=> (pc == '0));

    // R2: register 0 reads as zero
    a_r2_x0_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[25:21] == '0) |-> (rs_val == '0));

    // R9: non-control instructions advance by 4
    a_r9_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (opc != OP_BEQ && opc != OP_J) |=> (pc == $past(pc) + 32'd4));

    // R7: branch target or fall-through
    a_r7_beq_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_BEQ) |=> (pc == $past(pc) + 32'd4
                             + (($past(rs_val) == $past(rt_val)) ? $past(off4) : '0)));

    // R8: jump target
    a_r8_jump_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_J) |=> (pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}));

    // R6: a store writes memory and no register
    a_r6_store_only: assert property (@(posedge clk) disable iff (!rst_n)
        (opc == OP_SW) |-> (dm_we && !rf_we));

    // R7: control flow writes no state besides the PC
    a_r7_ctrl_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ((opc == OP_BEQ || opc == OP_J) && !ld_dmem_we) |-> (!rf_we && !dm_we));
endmodule

bind scp_core scp_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc         (pc),
    .instr      (instr),
    .rs_val     (rs_val),
    .rt_val     (rt_val),
    .rf_we      (rf_we),
    .dm_we      (dm_we),
    .ld_dmem_we (ld_dmem_we)
);

// File: tb/sim_scp_core.sv
`timescale 1ns/1ps
// Bench for scp_core: loads one program, walks a PC trace table and a
// register table, then directed reset tests.
module sim_scp_core;
    localparam int LDW = 6;
    localparam int NTRACE = 19;
    localparam int NPROG = 20;
    localparam int NREGX = 12;

    // Expected PC after each executed edge.
    localparam logic [31:0] PC_TRACE [NTRACE] = '{
        32'h04, 32'h08, 32'h0C, 32'h10, 32'h14, 32'h18, 32'h20, 32'h24,
        32'h28, 32'h2C, 32'h30, 32'h34, 32'h38, 32'h40, 32'h44, 32'h48,
        32'h4C, 32'h4C, 32'h4C };

    // Expected final register contents r0..r11.
    localparam logic [31:0] REG_EXP [NREGX] = '{
        32'h0, 32'h5, 32'hFFFFFFFD, 32'h2, 32'h2, 32'h0,
        32'h12345678, 32'h10, 32'h0, 32'h2, 32'h0, 32'hFFFFFFFD };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_imem_we = 1'b0;
    logic        ld_dmem_we = 1'b0;
    logic [LDW-1:0] ld_idx = '0;
    logic [31:0] ld_word = '0;
    logic [4:0]  dbg_sel = '0;
    logic [31:0] dbg_reg;
    logic [31:0] dbg_pc;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [31:0] prog [NPROG];

    always #2.5 clk = ~clk;

    scp_core u0 (
        .clk(clk), .rst_n(rst_n), .ld_imem_we(ld_imem_we), .ld_dmem_we(ld_dmem_we),
        .ld_idx(ld_idx), .ld_word(ld_word), .dbg_sel(dbg_sel),
        .dbg_reg(dbg_reg), .dbg_pc(dbg_pc)
    );

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, rs[4:0], rt[4:0], imm[15:0]};
    endfunction
    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'h00, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_j(input int tgt);
        return {6'h02, tgt[25:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input bit to_dmem, input int idx, input logic [31:0] w);
        ld_idx = idx[LDW-1:0];
        ld_word = w;
        ld_imem_we = !to_dmem;
        ld_dmem_we = to_dmem;
        @(posedge clk); #1;
        ld_imem_we = 1'b0;
        ld_dmem_we = 1'b0;
    endtask

    task automatic peek(input string req, input int r, input logic [31:0] exp);
        dbg_sel = r[4:0];
        #0.1;
        check(req, dbg_reg, exp);
    endtask

    initial begin
        // Program: word index i sits at byte PC 4*i.
        prog[0]  = enc_i(6'h08, 0, 1, 5);          // ADDI r1=5          (R4)
        prog[1]  = enc_i(6'h08, 0, 2, -3);         // ADDI r2=-3         (R4)
        prog[2]  = enc_r(1, 2, 3, 6'h20);          // ADD r3=r1+r2       (R3)
        prog[3]  = enc_i(6'h2B, 0, 3, 8);          // SW r3 -> word 2    (R6)
        prog[4]  = enc_i(6'h23, 0, 4, 8);          // LW r4 <- word 2    (R5)
        prog[5]  = enc_i(6'h08, 1, 0, 7);          // ADDI r0: discarded (R2)
        prog[6]  = enc_i(6'h04, 3, 4, 1);          // BEQ taken -> 0x20  (R7)
        prog[7]  = enc_i(6'h08, 0, 5, 99);         // skipped
        prog[8]  = enc_i(6'h04, 1, 2, 5);          // BEQ not taken      (R7)
        prog[9]  = enc_i(6'h08, 0, 7, 16);         // ADDI r7=16
        prog[10] = enc_i(6'h23, 7, 6, -4);         // LW r6 <- word 3    (R5)
        prog[11] = enc_i(6'h23, 0, 9, 11);         // LW r9, addr 11 -> word 2 (R5)
        prog[12] = 32'hFC00_0000;                  // unknown opcode     (R9)
        prog[13] = enc_r(1, 1, 10, 6'h22);         // unsupported funct  (R9)
        prog[14] = enc_j(16);                      // J 0x40             (R8)
        prog[15] = enc_i(6'h08, 0, 8, 1);          // skipped
        prog[16] = enc_i(6'h2B, 1, 2, 0);          // SW r2 -> addr 5 = word 1 (R6)
        prog[17] = enc_i(6'h23, 0, 11, 4);         // LW r11 <- word 1
        prog[18] = enc_r(1, 1, 0, 6'h20);          // ADD into r0        (R2)
        prog[19] = enc_i(6'h04, 0, 0, -1);         // self loop

        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 pc after reset", dbg_pc, 32'h0);
        peek("R1 r1 after reset", 1, 32'h0);
        peek("R1 r31 after reset", 31, 32'h0);

        for (int i = 0; i < NPROG; i++) put(1'b0, i, prog[i]);
        put(1'b1, 3, 32'h12345678);                // R11 backdoor data
        check("R1 pc held in reset", dbg_pc, 32'h0);

        rst_n = 1'b1;
        // Walk the PC trace table (R3 R4 R7 R8 R9).
        for (int i = 0; i < NTRACE; i++) begin
            @(posedge clk); #1;
            check($sformatf("R7/R8/R9 pc step %0d", i), dbg_pc, PC_TRACE[i]);
        end
        // Walk the register table via the debug port (R10).
        for (int r = 0; r < NREGX; r++)
            peek($sformatf("R10 reg r%0d", r), r, REG_EXP[r]);

        peek("R2 r0 stays zero", 0, 32'h0);
        peek("R11 backdoor word reached r6", 6, 32'h12345678);
        peek("R9 unsupported funct left r10", 10, 32'h0);
        peek("R5 low address bits ignored r9", 9, 32'h2);

        // Mid-run reset: state clears, program survives.
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R1 pc cleared mid-run", dbg_pc, 32'h0);
        peek("R1 r3 cleared mid-run", 3, 32'h0);
        peek("R1 r7 cleared mid-run", 7, 32'h0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R4 pc after rerun", dbg_pc, 32'h4);
        peek("R4 r1 after rerun", 1, 32'h5);
        @(posedge clk); #1;
        peek("R4 negative immediate r2", 2, 32'hFFFFFFFD);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog.
    initial begin
        #(5.0 * 20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule